// File: doc/BRIEF.md
# Finite-Difference Polynomial Tabulator

This block generates a table of polynomial values f(0), f(1), f(2) and so on, for any polynomial of degree six or less. It needs no multiplier. It keeps one value register and a chain of difference registers. On each advance, every difference adds the newly updated difference of the next higher order. The value then adds the new first difference. The whole chain settles through one combinational adder path and is captured on one clock edge.

The host does the conversion from coefficients to differences. It writes the starting value and the backward differences at n = 0 through an indexed load port, one register per cycle. The first difference is f(0) - f(-1), the second difference is the first difference of that sequence, and so on. For n^2 + n + 41 the host loads f = 41, d1 = 0 and d2 = 2, and the outputs are 41, 43, 47, 53, 61. After loading, each step pulse yields the next table entry with a one-cycle valid flag. The first pulse returns f(0) itself. A synchronous clear empties the block, and a sticky flag records signed wrap of the value register.

A three-state controller sequences the block:
- IDLE: the state after reset or clear. Steps are ignored here.
- PRIMED: entered from any state on a valid load write.
- RUN: a step in PRIMED emits f(0) and moves to RUN; a step in RUN advances the chain.
- Clear returns the controller to IDLE from every state.

Top module: `diff_tabulator`

## Requirements
- R1: After reset, val_out is 0, val_valid is 0 and ovf_sticky is 0.
- R2: A load with ld_idx 0 writes the value register, and ld_idx k (1 to 6) writes the k-th difference. A load with ld_idx 7 has no effect: the block stays in its state, so a following step from IDLE produces no valid output.
- R3: The first step after a load presents the loaded value unchanged on val_out, with val_valid high in the cycle after the step.
- R4: Each later step in RUN updates the differences from the highest order down to the first, then adds the new first difference to the value. The next table entry appears on val_out one cycle after the step. Quadratic and cubic loads give the expected sequences.
- R5: The highest difference never changes while stepping, so a sixth-degree load with only d6 = 1 yields C(n+5, 6).
- R6: val_valid is high only in the cycle after an accepted step, for exactly one cycle per step, and never after a step issued in IDLE.
- R7: All arithmetic is 64-bit two's complement with wrap. ovf_sticky sets when the value addition overflows as a signed sum, and it stays set until clear.
- R8: clr zeroes all registers, val_out, val_valid and ovf_sticky, and returns the controller to IDLE. It takes priority over load and step.
- R9: A load in the same cycle as a step wins, and the step is ignored. A load during RUN re-primes the block, so the next step presents the loaded value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all state |
| ld_en | input | 1 | Load write strobe |
| ld_idx | input | 3 | Register select: 0 value, 1..6 differences |
| ld_data | input | 64 | Load data |
| step | input | 1 | Step request |
| val_out | output | 64 | Current table value |
| val_valid | output | 1 | One-cycle flag marking a new val_out |
| ovf_sticky | output | 1 | Sticky signed-overflow flag of the value register |

## Verification
The bench builds the block with its default parameters: 64-bit registers and six differences. This gives the full degree-six chain, so a lone d6 seed exercises every adder. The 64-bit width means overflow is reached only by loading a value at the signed maximum, which the bench does to check the wrap and the sticky flag. The default 3-bit index also leaves one code, 7, that selects no register, so the ignored-write case is reachable.

// File: rtl/tab_pkg.sv
package tab_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PRIMED = 2'd1,
        ST_RUN    = 2'd2
    } tab_state_e;
endpackage

// File: rtl/tab_ctrl.sv
module tab_ctrl
    import tab_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic ld_hit,
    input  logic step,
    output logic show,
    output logic adv
);
    tab_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (clr) begin
            state_d = ST_IDLE;
        end else if (ld_hit) begin
            state_d = ST_PRIMED;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_PRIMED: if (step) state_d = ST_RUN;
                ST_RUN:    state_d = ST_RUN;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        show = 1'b0;
        adv  = 1'b0;
        if (!clr && !ld_hit && step) begin
            unique case (state_q)
                ST_IDLE:   ;
                ST_PRIMED: show = 1'b1;
                ST_RUN:    adv  = 1'b1;
                default:   ;
            endcase
        end
    end

    // R3
    primed_to_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PRIMED && step && !ld_hit && !clr) |=> (state_q == ST_RUN));

    // R8
    clr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (state_q == ST_IDLE));
endmodule

// File: rtl/tab_chain.sv
module tab_chain #(
    parameter int WIDTH = 64,
    parameter int ORDER = 6,
    parameter int IDXW  = $clog2(ORDER + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ld_hit,
    input  logic [IDXW-1:0]  ld_idx,
    input  logic [WIDTH-1:0] ld_data,
    input  logic             adv,
    output logic [WIDTH-1:0] value,
    output logic [WIDTH-1:0] value_nxt,
    output logic             ovf
);
    localparam int TOTW = (ORDER + 1) * WIDTH;

    logic [TOTW-1:0] regs_q;
    logic [TOTW-1:0] nxt_v;
    logic            ovf_now;

    for (genvar k = 0; k <= ORDER; k++) begin : g_add
        if (k == ORDER) begin : g_top
            assign nxt_v[k*WIDTH +: WIDTH] = regs_q[k*WIDTH +: WIDTH];
        end else begin : g_mid
            assign nxt_v[k*WIDTH +: WIDTH] =
                regs_q[k*WIDTH +: WIDTH] + nxt_v[(k+1)*WIDTH +: WIDTH];
        end
    end

    assign value     = regs_q[WIDTH-1:0];
    assign value_nxt = nxt_v[WIDTH-1:0];
    assign ovf_now   = (regs_q[WIDTH-1] == nxt_v[2*WIDTH-1]) &&
                       (nxt_v[WIDTH-1] != regs_q[WIDTH-1]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else if (clr) begin
            regs_q <= '0;
        end else begin
            for (int k = 0; k <= ORDER; k++) begin
                if (ld_hit && ld_idx == IDXW'(k))
                    regs_q[k*WIDTH +: WIDTH] <= ld_data;
                else if (adv)
                    regs_q[k*WIDTH +: WIDTH] <= nxt_v[k*WIDTH +: WIDTH];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              ovf <= 1'b0;
        else if (clr)            ovf <= 1'b0;
        else if (adv && ovf_now) ovf <= 1'b1;
    end

    // R5
    top_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !(ld_hit && ld_idx == IDXW'(ORDER)))
            |=> $stable(regs_q[TOTW-1 -: WIDTH]));

    // R7
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr) |=> ovf);
endmodule

// File: rtl/diff_tabulator.sv
module diff_tabulator #(
    parameter int WIDTH = 64,
    parameter int ORDER = 6,
    parameter int IDXW  = $clog2(ORDER + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ld_en,
    input  logic [IDXW-1:0]  ld_idx,
    input  logic [WIDTH-1:0] ld_data,
    input  logic             step,
    output logic [WIDTH-1:0] val_out,
    output logic             val_valid,
    output logic             ovf_sticky
);
    logic             ld_hit;
    logic             show;
    logic             adv;
    logic [WIDTH-1:0] value;
    logic [WIDTH-1:0] value_nxt;

    assign ld_hit = ld_en && (ld_idx <= IDXW'(ORDER));

    tab_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .ld_hit (ld_hit),
        .step   (step),
        .show   (show),
        .adv    (adv)
    );

    tab_chain #(.WIDTH(WIDTH), .ORDER(ORDER), .IDXW(IDXW)) u_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .ld_hit    (ld_hit),
        .ld_idx    (ld_idx),
        .ld_data   (ld_data),
        .adv       (adv),
        .value     (value),
        .value_nxt (value_nxt),
        .ovf       (ovf_sticky)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_out   <= '0;
            val_valid <= 1'b0;
        end else if (clr) begin
            val_out   <= '0;
            val_valid <= 1'b0;
        end else begin
            val_valid <= show | adv;
            if (show)     val_out <= value;
            else if (adv) val_out <= value_nxt;
        end
    end

    // R6
    valid_after_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        val_valid |-> $past(step));

    // R8
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (val_out == '0 && !val_valid && !ovf_sticky));
endmodule

// File: tb/sim_diff_tabulator.sv
module sim_diff_tabulator;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        ld_en = 1'b0;
    logic [2:0]  ld_idx = '0;
    logic [63:0] ld_data = '0;
    logic        step = 1'b0;
    logic [63:0] val_out;
    logic        val_valid;
    logic        ovf_sticky;

    int ntests = 0;
    int nfail  = 0;
    bit done   = 1'b0;

    // load sets per case: f, d1..d6 ; expected outputs for five steps
    localparam longint LD  [2][7] = '{'{41, 0, 2, 0, 0, 0, 0},
                                      '{0, 1, -6, 6, 0, 0, 0}};
    localparam longint EXP [2][5] = '{'{41, 43, 47, 53, 61},
                                      '{0, 1, 8, 27, 64}};

    always #(CLK_PERIOD/2) clk = ~clk;

    diff_tabulator u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .ld_en(ld_en), .ld_idx(ld_idx),
        .ld_data(ld_data), .step(step), .val_out(val_out),
        .val_valid(val_valid), .ovf_sticky(ovf_sticky)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        ntests++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load(input logic [2:0] idx, input logic [63:0] d);
        @(negedge clk); ld_en = 1'b1; ld_idx = idx; ld_data = d;
        @(negedge clk); ld_en = 1'b0;
    endtask

    task automatic pulse;
        @(negedge clk); step = 1'b1;
        @(negedge clk); step = 1'b0;
    endtask

    task automatic do_clear;
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    function automatic longint binom(input int n, input int k);
        longint r = 1;
        for (int i = 0; i < k; i++) r = r * (n - i) / (i + 1);
        return r;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 val_out", val_out, 64'd0);
        chk("R1 val_valid", {63'd0, val_valid}, 64'd1 - 64'd1);
        chk("R1 ovf", {63'd0, ovf_sticky}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6 step in IDLE gives nothing
        pulse();
        chk("R6 idle step valid", {63'd0, val_valid}, 64'd0);

        // R3 R4: table-driven quadratic and cubic
        for (int c = 0; c < 2; c++) begin
            do_clear();
            for (int i = 0; i < 7; i++) load(3'(i), 64'(LD[c][i]));
            for (int s = 0; s < 5; s++) begin
                pulse();
                chk(s == 0 ? "R3 first step" : "R4 next value", val_out, 64'(EXP[c][s]));
                chk("R6 valid high", {63'd0, val_valid}, 64'd1);
                @(negedge clk);
                chk("R6 valid one cycle", {63'd0, val_valid}, 64'd0);
            end
        end

        // R9 load during RUN re-primes
        load(3'd0, 64'd100);
        pulse();
        chk("R9 reprime", val_out, 64'd100);

        // R9 load and step same cycle: step ignored
        @(negedge clk); ld_en = 1'b1; ld_idx = 3'd0; ld_data = 64'd5; step = 1'b1;
        @(negedge clk); ld_en = 1'b0; step = 1'b0;
        chk("R9 step ignored", {63'd0, val_valid}, 64'd0);
        pulse();
        chk("R9 loaded value", val_out, 64'd5);

        // R5 sixth-degree seed: only d6 = 1
        do_clear();
        load(3'd6, 64'd1);
        pulse();
        chk("R5 f0", val_out, 64'd0);
        for (int n = 1; n <= 6; n++) begin
            pulse();
            chk("R5 sixth degree", val_out, 64'(binom(n + 5, 6)));
        end

        // R2 index 7 ignored
        do_clear();
        load(3'd7, 64'd99);
        pulse();
        chk("R2 idx7 no valid", {63'd0, val_valid}, 64'd0);
        chk("R2 idx7 no value", val_out, 64'd0);

        // R7 overflow wrap and sticky
        do_clear();
        load(3'd0, 64'h7FFF_FFFF_FFFF_FFFF);
        load(3'd2, 64'd1);
        pulse();
        chk("R7 max value", val_out, 64'h7FFF_FFFF_FFFF_FFFF);
        chk("R7 no ovf yet", {63'd0, ovf_sticky}, 64'd0);
        pulse();
        chk("R7 wrap", val_out, 64'h8000_0000_0000_0000);
        chk("R7 ovf set", {63'd0, ovf_sticky}, 64'd1);
        pulse();
        chk("R7 after wrap", val_out, 64'h8000_0000_0000_0002);
        chk("R7 ovf sticky", {63'd0, ovf_sticky}, 64'd1);

        // R8 clear with simultaneous step
        @(negedge clk); clr = 1'b1; step = 1'b1;
        @(negedge clk); clr = 1'b0; step = 1'b0;
        chk("R8 val_out", val_out, 64'd0);
        chk("R8 valid", {63'd0, val_valid}, 64'd0);
        chk("R8 ovf", {63'd0, ovf_sticky}, 64'd0);
        pulse();
        chk("R8 idle after clear", {63'd0, val_valid}, 64'd0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end
endmodule